// File: doc/BRIEF.md
# E1 Multiframe Transmit Framer

This block produces the serial bit stream of a 2.048 Mbit/s primary-rate line that carries both the 256-bit frame structure and the 16-frame multiframe structure. It advances one bit on every cycle in which the bit-rate enable is high. The most significant bit of each 8-bit timeslot goes out first. A 16-frame multiframe lasts 2 ms, and each 256-bit frame lasts 125 µs.

Thirty timeslots per frame carry telephone payload. A byte source supplies this payload. The framer asks the source for each byte one timeslot before the byte is due. Timeslot 0 carries the frame alignment word or the alarm and fill bits, chosen by the parity of the frame number. Its first bit always comes from an external error-check input. Timeslot 16 carries the multiframe alignment word in frame 0. In frames 1 to 15 it carries two 4-bit signalling words, taken from a 30-entry register file. Two strobes mark the first bit of every frame and the first bit of every multiframe. Line coding, clock recovery and the checksum are computed outside this block.

Top module: `e1tx_framer`

## Requirements
- R1: After reset, and before the first bit enable, `line_out`, `frame_start`, `mf_start` and `pay_req` are all 0.
- R2: While `bit_en` is low the framer does not advance. `line_out`, `frame_start` and `mf_start` hold their values, and `pay_req` stays 0.
- R3: Positions are counted as 8 bits per timeslot, 32 timeslots per frame and 16 frames per multiframe. `frame_start` is 1 exactly while `line_out` carries bit 1 of timeslot 0. `mf_start` is 1 exactly while this is true and the frame number is 0. Each output bit appears one clock after the enabled cycle in which it is chosen, and it holds until the next enabled cycle.
- R4: In even-numbered frames, bits 2 to 8 of timeslot 0 are 0,0,1,1,0,1,1, in that order.
- R5: In odd-numbered frames, timeslot 0 is sent as follows. Bit 2 is 1. Bit 3 is `rai_alarm` and bit 6 is `aux_alarm`. Bits 4, 5, 7 and 8 are 1.
- R6: Bit 1 of timeslot 0 in every frame equals `crc_bit` as sampled in the enabled cycle of that bit.
- R7: In frame 0, bits 1 to 4 of timeslot 16 are 0 and bit 6 is `mf_alarm`. Bits 5, 7 and 8 are 1.
- R8: In frame n (1 to 15), bits 1 to 4 of timeslot 16 carry the signalling word of channel n, and bits 5 to 8 carry that of channel n+15. Each word is sent with its bit 3 first.
- R9: A signalling write with `sig_chan` from 1 to 30 replaces that channel's word on the next clock. A write with `sig_chan` equal to 0 or 31 changes no word. Every word resets to 4'b1101.
- R10: In the enabled cycle of bit 1 of timeslot s, `pay_req` is 1 if timeslot s+1 (modulo 32) is a payload slot (any slot except 0 and 16). In that case `pay_slot` equals s+1. In every other cycle `pay_req` is 0.
- R11: A payload timeslot sends, MSB first, the `pay_data` byte that was present with `pay_valid` high in the cycle of its request. If `pay_valid` was low in that cycle, the timeslot sends 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-rate enable, one pulse per line bit |
| crc_bit | input | 1 | Bit 1 of timeslot 0 for the current frame |
| rai_alarm | input | 1 | Remote loss-of-frame alarm, sent in bit 3 of odd frames |
| aux_alarm | input | 1 | Second alarm indication, sent in bit 6 of odd frames |
| mf_alarm | input | 1 | Loss-of-multiframe alarm, sent in timeslot 16 of frame 0 |
| sig_wr | input | 1 | Signalling word write strobe |
| sig_chan | input | 5 | Channel number written (1 to 30 valid) |
| sig_data | input | 4 | Signalling word to write |
| pay_req | output | 1 | Request for the payload byte of the next timeslot |
| pay_slot | output | 5 | Timeslot index of the byte requested |
| pay_valid | input | 1 | Source has a byte in the request cycle |
| pay_data | input | 8 | Payload byte answering the request |
| line_out | output | 1 | Serial line bit |
| frame_start | output | 1 | High during bit 1 of timeslot 0 |
| mf_start | output | 1 | High during bit 1 of timeslot 0 of frame 0 |

## Verification
The framer is run over full multiframes under four input settings, and every line bit is compared. The first setting has all alarms and the check bit low, with a slot-dependent payload. This exposes any misplaced alignment word or any bit-order slip. The second setting raises every alarm and the check bit, which tells apart the alarm positions from the fixed-one fill positions. A third setting runs with the byte source absent and then present under a new key. This shows whether idle fill and the one-slot lead of each request are correct. Last, distinct signalling words are loaded, including writes to the invalid channel numbers. This shows whether the channel n / n+15 pairing and the ignored addresses are right. A stall with the enable held low checks that nothing advances.

// File: rtl/e1tx_pkg.sv
package e1tx_pkg;

    localparam int NUM_SLOTS     = 32;
    localparam int BITS_PER_SLOT = 8;
    localparam int FRAMES_PER_MF = 16;
    localparam int NUM_CHANNELS  = 30;
    localparam int SIG_W         = 4;

    localparam int SLOT_W  = $clog2(NUM_SLOTS);
    localparam int BIT_W   = $clog2(BITS_PER_SLOT);
    localparam int FRAME_W = $clog2(FRAMES_PER_MF);
    localparam int CHAN_W  = $clog2(NUM_CHANNELS + 1);
    localparam int HALF_CH = NUM_CHANNELS / 2;

    localparam int FAS_SLOT = 0;
    localparam int SIG_SLOT = NUM_SLOTS / 2;

    localparam logic [BITS_PER_SLOT-2:0] ALIGN_WORD = 7'b0011011;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [SLOT_W-1:0]  slot;
        logic [BIT_W-1:0]   bitn;
    } pos_t;

    function automatic logic slot_is_payload(input logic [SLOT_W-1:0] s);
        return (s != SLOT_W'(FAS_SLOT)) && (s != SLOT_W'(SIG_SLOT));
    endfunction

endpackage

// File: rtl/e1tx_position.sv
module e1tx_position
    import e1tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    output pos_t pos
);

    localparam logic [BIT_W-1:0]   LAST_BIT   = BIT_W'(BITS_PER_SLOT - 1);
    localparam logic [SLOT_W-1:0]  LAST_SLOT  = SLOT_W'(NUM_SLOTS - 1);
    localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(FRAMES_PER_MF - 1);

    typedef struct packed {
        pos_t p;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bit_en) begin
            if (st_q.p.bitn == LAST_BIT) begin
                st_d.p.bitn = '0;
                if (st_q.p.slot == LAST_SLOT) begin
                    st_d.p.slot  = '0;
                    st_d.p.frame = (st_q.p.frame == LAST_FRAME) ? '0 : st_q.p.frame + 1'b1;
                end else begin
                    st_d.p.slot = st_q.p.slot + 1'b1;
                end
            end else begin
                st_d.p.bitn = st_q.p.bitn + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos = st_q.p;

    // R2: position frozen while the enable is low
    a_r2_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(st_q));

    // R3: the last bit of frame 15 wraps to the multiframe start
    a_r3_mf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && st_q.p.frame == LAST_FRAME && st_q.p.slot == LAST_SLOT &&
         st_q.p.bitn == LAST_BIT) |=> (st_q == '0));

endmodule

// File: rtl/e1tx_sig_regs.sv
module e1tx_sig_regs
    import e1tx_pkg::*;
#(
    parameter logic [SIG_W-1:0] SIG_RESET = 4'b1101
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CHAN_W-1:0]  wr_chan,
    input  logic [SIG_W-1:0]   wr_data,
    input  logic [FRAME_W-1:0] rd_frame,
    output logic [SIG_W-1:0]   rd_lo,
    output logic [SIG_W-1:0]   rd_hi
);

    logic [NUM_CHANNELS*SIG_W-1:0] words;

    for (genvar ch = 1; ch <= NUM_CHANNELS; ch++) begin : g_chan
        typedef struct packed {
            logic [SIG_W-1:0] word;
        } cst_t;

        cst_t c_d, c_q;

        always_comb begin
            c_d = c_q;
            if (wr_en && wr_chan == CHAN_W'(ch)) c_d.word = wr_data;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) c_q.word <= SIG_RESET;
            else        c_q      <= c_d;
        end

        assign words[(ch-1)*SIG_W +: SIG_W] = c_q.word;
    end

    logic [CHAN_W-1:0] lo_idx, hi_idx;

    always_comb begin
        lo_idx = (rd_frame == '0) ? '0 : CHAN_W'(rd_frame - 1'b1);
        hi_idx = lo_idx + CHAN_W'(HALF_CH);
        rd_lo  = words[lo_idx*SIG_W +: SIG_W];
        rd_hi  = words[hi_idx*SIG_W +: SIG_W];
    end

    // R9: writes to channel 0 or above the last channel leave every word unchanged
    a_r9_bad_chan_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_chan == '0 || wr_chan > CHAN_W'(NUM_CHANNELS))) |=> $stable(words));

    // R9: without a write nothing moves
    a_r9_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(words));

endmodule

// File: rtl/e1tx_ovh_byte.sv
module e1tx_ovh_byte
    import e1tx_pkg::*;
(
    input  logic [FRAME_W-1:0]       frame,
    input  logic                     is_sig_slot,
    input  logic                     crc_bit,
    input  logic                     rai_alarm,
    input  logic                     aux_alarm,
    input  logic                     mf_alarm,
    input  logic [SIG_W-1:0]         sig_lo,
    input  logic [SIG_W-1:0]         sig_hi,
    output logic [BITS_PER_SLOT-1:0] ovh
);

    logic [BITS_PER_SLOT-1:0] ts0_even, ts0_odd, ts16_mf, ts16_sig;

    always_comb begin
        ts0_even = {crc_bit, ALIGN_WORD};
        ts0_odd  = {crc_bit, 1'b1, rai_alarm, 1'b1, 1'b1, aux_alarm, 1'b1, 1'b1};
        ts16_mf  = {4'b0000, 1'b1, mf_alarm, 1'b1, 1'b1};
        ts16_sig = {sig_lo, sig_hi};

        if (is_sig_slot) ovh = (frame == '0) ? ts16_mf : ts16_sig;
        else             ovh = frame[0] ? ts0_odd : ts0_even;
    end

endmodule

// File: rtl/e1tx_pay_fetch.sv
module e1tx_pay_fetch
    import e1tx_pkg::*;
#(
    parameter logic [BITS_PER_SLOT-1:0] IDLE_BYTE = 8'hFF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bit_en,
    input  pos_t                     pos,
    input  logic                     pay_valid,
    input  logic [BITS_PER_SLOT-1:0] pay_data,
    output logic                     pay_req,
    output logic [SLOT_W-1:0]        pay_slot,
    output logic [BITS_PER_SLOT-1:0] cur_byte
);

    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BITS_PER_SLOT - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    typedef struct packed {
        logic [BITS_PER_SLOT-1:0] nxt;
        logic [BITS_PER_SLOT-1:0] cur;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        pay_slot = (pos.slot == LAST_SLOT) ? '0 : pos.slot + 1'b1;
        pay_req  = bit_en && (pos.bitn == '0) && slot_is_payload(pay_slot);

        st_d = st_q;
        if (pay_req) st_d.nxt = pay_valid ? pay_data : IDLE_BYTE;
        if (bit_en && pos.bitn == LAST_BIT) st_d.cur = st_q.nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.nxt <= IDLE_BYTE;
            st_q.cur <= IDLE_BYTE;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_byte = st_q.cur;

    // R11: an unanswered request stores the idle fill
    a_r11_idle_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_req && !pay_valid) |=> (st_q.nxt == IDLE_BYTE));

    // R11: an answered request stores the offered byte
    a_r11_take_data: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_req && pay_valid) |=> (st_q.nxt == $past(pay_data)));

    // R10: requests never come in consecutive cycles
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pay_req |=> !pay_req);

endmodule

// File: rtl/e1tx_framer.sv
module e1tx_framer
    import e1tx_pkg::*;
#(
    parameter logic [SIG_W-1:0]         SIG_RESET = 4'b1101,
    parameter logic [BITS_PER_SLOT-1:0] IDLE_BYTE = 8'hFF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bit_en,
    input  logic                     crc_bit,
    input  logic                     rai_alarm,
    input  logic                     aux_alarm,
    input  logic                     mf_alarm,
    input  logic                     sig_wr,
    input  logic [CHAN_W-1:0]        sig_chan,
    input  logic [SIG_W-1:0]         sig_data,
    output logic                     pay_req,
    output logic [SLOT_W-1:0]        pay_slot,
    input  logic                     pay_valid,
    input  logic [BITS_PER_SLOT-1:0] pay_data,
    output logic                     line_out,
    output logic                     frame_start,
    output logic                     mf_start
);

    localparam logic [SLOT_W-1:0] FAS_S = SLOT_W'(FAS_SLOT);
    localparam logic [SLOT_W-1:0] SIG_S = SLOT_W'(SIG_SLOT);
    localparam logic [BIT_W-1:0]  MSB_I = BIT_W'(BITS_PER_SLOT - 1);

    pos_t                     pos;
    logic [SIG_W-1:0]         sig_lo, sig_hi;
    logic [BITS_PER_SLOT-1:0] ovh, cur_byte, tx_byte;
    logic                     tx_bit, at_fas, at_overhead;

    e1tx_position u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .pos    (pos)
    );

    e1tx_sig_regs #(.SIG_RESET(SIG_RESET)) u_sig (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sig_wr),
        .wr_chan  (sig_chan),
        .wr_data  (sig_data),
        .rd_frame (pos.frame),
        .rd_lo    (sig_lo),
        .rd_hi    (sig_hi)
    );

    e1tx_ovh_byte u_ovh (
        .frame       (pos.frame),
        .is_sig_slot (pos.slot == SIG_S),
        .crc_bit     (crc_bit),
        .rai_alarm   (rai_alarm),
        .aux_alarm   (aux_alarm),
        .mf_alarm    (mf_alarm),
        .sig_lo      (sig_lo),
        .sig_hi      (sig_hi),
        .ovh         (ovh)
    );

    e1tx_pay_fetch #(.IDLE_BYTE(IDLE_BYTE)) u_pay (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .pos       (pos),
        .pay_valid (pay_valid),
        .pay_data  (pay_data),
        .pay_req   (pay_req),
        .pay_slot  (pay_slot),
        .cur_byte  (cur_byte)
    );

    typedef struct packed {
        logic line;
        logic fs;
        logic ms;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        at_overhead = (pos.slot == FAS_S) || (pos.slot == SIG_S);
        at_fas      = (pos.slot == FAS_S) && (pos.bitn == '0);
        tx_byte     = at_overhead ? ovh : cur_byte;
        tx_bit      = tx_byte[MSB_I - pos.bitn];

        out_d = out_q;
        if (bit_en) begin
            out_d.line = tx_bit;
            out_d.fs   = at_fas;
            out_d.ms   = at_fas && (pos.frame == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign line_out    = out_q.line;
    assign frame_start = out_q.fs;
    assign mf_start    = out_q.ms;

    // R6: check bit passes straight to bit 1 of timeslot 0
    a_r6_crc_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && pos.slot == FAS_S && pos.bitn == '0) |=> (line_out == $past(crc_bit)));

    // R3: a multiframe strobe only appears inside a frame strobe
    a_r3_mf_within_frame: assert property (@(posedge clk) disable iff (!rst_n)
        mf_start |-> frame_start);

    // R5: fill positions of odd frames are ones
    a_r5_odd_fill_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && pos.slot == FAS_S && pos.frame[0] &&
         (pos.bitn == 3'd1 || pos.bitn == 3'd3 || pos.bitn == 3'd4 ||
          pos.bitn == 3'd6 || pos.bitn == 3'd7)) |=> line_out);

    // R7: multiframe word is four zeros
    a_r7_mf_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && pos.slot == SIG_S && pos.frame == '0 && pos.bitn < 3'd4) |=> !line_out);

    // R2: outputs hold without an enable
    a_r2_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(line_out) && $stable(frame_start) && $stable(mf_start)));

endmodule

// File: tb/e1tx_framer_test.sv
`timescale 1ns/1ps
module e1tx_framer_test;
    import e1tx_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, bit_en, crc_bit, rai_alarm, aux_alarm, mf_alarm;
    logic       sig_wr;
    logic [4:0] sig_chan;
    logic [3:0] sig_data;
    logic       pay_req, pay_valid, line_out, frame_start, mf_start;
    logic [4:0] pay_slot;
    logic [7:0] pay_data, pat_key;
    logic       src_on;

    assign pay_valid = src_on;
    assign pay_data  = {pay_slot, 3'b011} ^ pat_key;

    e1tx_framer uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .crc_bit(crc_bit),
        .rai_alarm(rai_alarm), .aux_alarm(aux_alarm), .mf_alarm(mf_alarm),
        .sig_wr(sig_wr), .sig_chan(sig_chan), .sig_data(sig_data),
        .pay_req(pay_req), .pay_slot(pay_slot), .pay_valid(pay_valid),
        .pay_data(pay_data), .line_out(line_out), .frame_start(frame_start),
        .mf_start(mf_start)
    );

    int  vectors = 0;
    int  fails   = 0;
    int  fr = 0, sl = 0, bt = 0;
    bit  done = 0;
    logic [7:0] exp_pay [0:31];
    logic [3:0] sig_sh  [0:31];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h (frame %0d slot %0d bit %0d)", tag, act, exp, fr, sl, bt);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    // expected byte of the current position, from the requirements
    task automatic exp_byte(output logic [7:0] b, output string tag);
        if (sl == 0) begin
            if (fr % 2 == 0) begin b = {crc_bit, 7'b0011011}; tag = "R4"; end
            else begin b = {crc_bit, 1'b1, rai_alarm, 1'b1, 1'b1, aux_alarm, 1'b1, 1'b1}; tag = "R5"; end
            if (bt == 0) tag = "R6";
        end else if (sl == 16) begin
            if (fr == 0) begin b = {4'b0000, 1'b1, mf_alarm, 2'b11}; tag = "R7"; end
            else begin b = {sig_sh[fr], sig_sh[fr+15]}; tag = "R8"; end
        end else begin
            b = exp_pay[sl]; tag = "R11";
        end
    endtask

    task automatic send_bit();
        logic [7:0] b;
        string      tag;
        logic       e, efs, ems;
        int         nxt;
        @(negedge clk);
        bit_en = 1'b1;
        #1;
        nxt = (sl == 31) ? 0 : sl + 1;
        if (bt == 0 && nxt != 0 && nxt != 16) begin
            check("R10 req", {31'd0, pay_req}, 32'd1);
            check("R10 slot", {27'd0, pay_slot}, nxt);
            exp_pay[nxt] = src_on ? ({nxt[4:0], 3'b011} ^ pat_key) : 8'hFF;
        end else begin
            check("R10 noreq", {31'd0, pay_req}, 32'd0);
        end
        exp_byte(b, tag);
        e   = b[7-bt];
        efs = (sl == 0 && bt == 0);
        ems = efs && (fr == 0);
        @(negedge clk);
        bit_en = 1'b0;
        check(tag, {31'd0, line_out}, {31'd0, e});
        check("R3 frame_start", {31'd0, frame_start}, {31'd0, efs});
        check("R3 mf_start", {31'd0, mf_start}, {31'd0, ems});
        if (bt == 7) begin
            bt = 0;
            if (sl == 31) begin sl = 0; fr = (fr + 1) % 16; end
            else sl++;
        end else bt++;
    endtask

    task automatic run_frames(input int n);
        repeat (n * 256) send_bit();
    endtask

    task automatic sig_write(input logic [4:0] ch, input logic [3:0] w);
        @(negedge clk);
        sig_wr = 1'b1; sig_chan = ch; sig_data = w;
        @(negedge clk);
        sig_wr = 1'b0;
        if (ch >= 1 && ch <= 30) sig_sh[ch] = w;
    endtask

    task automatic test_reset();
        #1;
        check("R1 line", {31'd0, line_out}, 32'd0);
        check("R1 fs", {31'd0, frame_start}, 32'd0);
        check("R1 ms", {31'd0, mf_start}, 32'd0);
        check("R1 req", {31'd0, pay_req}, 32'd0);
    endtask

    task automatic test_stall();
        logic l0, f0, m0;
        repeat (3) send_bit();
        l0 = line_out; f0 = frame_start; m0 = mf_start;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            check("R2 line", {31'd0, line_out}, {31'd0, l0});
            check("R2 fs", {31'd0, frame_start}, {31'd0, f0});
            check("R2 ms", {31'd0, mf_start}, {31'd0, m0});
            check("R2 req", {31'd0, pay_req}, 32'd0);
        end
        run_frames(1);
    endtask

    task automatic test_basic_mf();
        crc_bit = 0; rai_alarm = 0; aux_alarm = 0; mf_alarm = 0;
        src_on = 1; pat_key = 8'h00;
        run_frames(16);
    endtask

    task automatic test_alarms();
        crc_bit = 1; rai_alarm = 1; aux_alarm = 1; mf_alarm = 1;
        pat_key = 8'h3C;
        run_frames(16);
        crc_bit = 0; rai_alarm = 0; aux_alarm = 0; mf_alarm = 0;
    endtask

    task automatic test_idle();
        src_on = 0;
        run_frames(2);
        src_on = 1; pat_key = 8'hA5;
        run_frames(2);
    endtask

    task automatic test_sig();
        for (int ch = 1; ch <= 30; ch++) sig_write(ch[4:0], 4'((ch * 7 + 3) & 15));
        sig_write(5'd0, 4'h0);
        sig_write(5'd31, 4'h0);
        rai_alarm = 1;
        run_frames(16);
    endtask

    initial begin
        #(150000 * 20);
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        rst_n = 0; bit_en = 0; crc_bit = 0; rai_alarm = 0; aux_alarm = 0; mf_alarm = 0;
        sig_wr = 0; sig_chan = '0; sig_data = '0; src_on = 1; pat_key = 8'h00;
        for (int i = 0; i < 32; i++) begin exp_pay[i] = 8'hFF; sig_sh[i] = 4'b1101; end
        repeat (4) @(negedge clk);
        rst_n = 1;
        test_reset();
        test_stall();
        test_basic_mf();
        test_alarms();
        test_idle();
        test_sig();
        finish_run();
    end

endmodule